// File: doc/BRIEF.md
# GPIO interrupt slot mapper

This block watches a wide vector of general-purpose input pins and lets software steer any of them into a small pool of interrupt slots. Each slot carries its own source-pin index, an enable flag and a two-bit sense mode. The selected pin is resynchronised and then checked for a rising edge, a falling edge, a high level or a low level. A hit sets a sticky per-slot status bit, and that bit drives the slot's active-high level interrupt line toward the parent interrupt controller.

Software programs the slots over a simple 32-bit register bus with write and read strobes. Read data is registered and appears on the cycle after the read strobe. The per-slot select and enable fields are packed as bytes, four slots per word. The sense fields are packed as two-bit fields, sixteen slots per word. A slot's status bit is cleared by writing a zero into its position of the status word, and ones written to the status word have no effect.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous reset, every register reads zero and every interrupt line is low. This leaves all slots disabled, in rising-edge mode, selecting pin 0.
- R2: Slot n's select byte sits in the word at offset 0x30 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)]. Bit 7 of the byte is the slot enable and bits 6:0 are the pin index. A written byte reads back unchanged.
- R3: Slot n's sense field is two bits wide at bit 2*(n%16) of offset 0x24 (slots 0-15) or offset 0x28 (slots 16-31). The encodings are 0 = rising edge, 1 = falling edge, 2 = high level and 3 = low level. A written field reads back unchanged.
- R4: In rising-edge mode, a 0-to-1 change on the selected pin sets the slot's status. The status bit then stays set after the pin returns low, until software clears it.
- R5: In falling-edge mode, a 1-to-0 change on the selected pin sets the slot's status. A 0-to-1 change does not.
- R6: In high-level mode the status is set on every cycle the pin is high, so a clear while the pin is high has no lasting effect. A clear while the pin is low leaves the bit clear.
- R7: In low-level mode the status is set on every cycle the pin is low, and a clear takes effect only while the pin is high.
- R8: A slot whose enable bit is 0 never sets its status or raises its interrupt, whatever its pin does.
- R9: A write to offset 0x20 clears exactly the status bits written as 0. Bits written as 1 keep their value, and writing 1 never sets a bit.
- R10: When a clear and a detected event hit the same slot in the same cycle, the status bit stays set.
- R11: Rewriting a slot's select or sense fields with different values suppresses edge detection for the following cycle. Switching from a low pin to a high pin in rising-edge mode therefore sets no status.
- R12: Reads of any offset other than 0x20, the sense words and the select words return zero. A pin index at or beyond the number of pins reads as a constant 0 input.
- R13: Interrupt line n equals status bit n as read at offset 0x20. It is set three clock edges after a pin change reaches the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| gpio_in | input | NUM_PINS | Asynchronous general-purpose inputs |
| irq_out | output | NUM_SLOTS | Per-slot active-high level interrupts |

## Verification
The bench builds the block with all 32 slots and only 12 pins. This keeps the register layout at full size while shrinking the pin space, so every slot can be swept through all four sense modes on a pin derived from its index. Each step runs a complete rise/clear/fall sequence with the full 32-bit interrupt vector compared. The small pin count also puts indices beyond the last pin within reach, which exercises the constant-zero fallback.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 7;
  localparam int LANE_W   = 8;
  localparam int LANE_EN  = 7;
  localparam int PIN_SPAN = 1 << SEL_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  localparam addr_t STAT_OFS = 8'h20;
  localparam addr_t SNS_BASE = 8'h24;
  localparam addr_t SEL_BASE = 8'h30;

  function automatic addr_t sel_addr(input int slot);
    return addr_t'(int'(SEL_BASE) + 4 * (slot / 4));
  endfunction

  function automatic addr_t sns_addr(input int slot);
    return addr_t'(int'(SNS_BASE) + 4 * (slot / 16));
  endfunction
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  addr_t                             bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  input  logic [NUM_SLOTS-1:0]              status,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0]   slot_pin,
  output logic [NUM_SLOTS-1:0]              slot_en,
  output logic [NUM_SLOTS-1:0][1:0]         slot_sense,
  output logic [NUM_SLOTS-1:0]              hist_clr,
  output logic [NUM_SLOTS-1:0]              stat_clr
);
  logic wr_stat;
  assign wr_stat = bus_wr && (bus_addr == STAT_OFS);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam addr_t SEL_A = sel_addr(s);
    localparam addr_t SNS_A = sns_addr(s);
    localparam int    LANE  = s % 4;
    localparam int    FLD   = s % 16;

    logic              sel_hit;
    logic              sns_hit;
    logic [LANE_W-1:0] lane_w;
    logic [1:0]        sns_w;

    assign sel_hit = bus_wr && (bus_addr == SEL_A);
    assign sns_hit = bus_wr && (bus_addr == SNS_A);
    assign lane_w  = bus_wdata[LANE_W*LANE +: LANE_W];
    assign sns_w   = bus_wdata[2*FLD +: 2];

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_pin[s]   <= '0;
        slot_en[s]    <= 1'b0;
        slot_sense[s] <= SNS_RISE;
        hist_clr[s]   <= 1'b0;
      end else begin
        hist_clr[s] <= 1'b0;
        if (sel_hit) begin
          slot_pin[s] <= lane_w[SEL_W-1:0];
          slot_en[s]  <= lane_w[LANE_EN];
          if (lane_w[SEL_W-1:0] != slot_pin[s] || lane_w[LANE_EN] != slot_en[s])
            hist_clr[s] <= 1'b1;
        end
        if (sns_hit) begin
          slot_sense[s] <= sns_w;
          if (sns_w != slot_sense[s])
            hist_clr[s] <= 1'b1;
        end
      end
    end

    assign stat_clr[s] = wr_stat && !bus_wdata[s];
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (bus_addr == STAT_OFS)
      rd_next[NUM_SLOTS-1:0] = status;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (bus_addr == sel_addr(s))
        rd_next[LANE_W*(s%4) +: LANE_W] = {slot_en[s], slot_pin[s]};
      if (bus_addr == sns_addr(s))
        rd_next[2*(s%16) +: 2] = slot_sense[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gir_slot.sv
module gir_slot
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 123
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] gpio_s,
  input  logic [SEL_W-1:0]    pin,
  input  logic                en,
  input  logic [1:0]          sense,
  input  logic                hist_clr,
  input  logic                clr,
  output logic                evt,
  output logic                status
);
  logic [PIN_SPAN-1:0] padded;
  logic                cur;
  logic                prev;
  logic                edge_hit;
  logic                lvl_hit;

  assign padded = PIN_SPAN'(gpio_s);
  assign cur    = padded[pin];

  always_comb begin
    edge_hit = 1'b0;
    lvl_hit  = 1'b0;
    unique case (sense)
      SNS_RISE: edge_hit = !hist_clr && cur && !prev;
      SNS_FALL: edge_hit = !hist_clr && !cur && prev;
      SNS_HIGH: lvl_hit  = cur;
      SNS_LOW:  lvl_hit  = !cur;
      default:  lvl_hit  = 1'b0;
    endcase
  end

  assign evt = en && (edge_hit || lvl_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      status <= 1'b0;
    end else begin
      prev <= cur;
      if (evt)
        status <= 1'b1;
      else if (clr)
        status <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_PINS  = 123
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]  gpio_in,
  output logic [NUM_SLOTS-1:0] irq_out
);
  logic [NUM_PINS-1:0]             gpio_s;
  logic [NUM_SLOTS-1:0][SEL_W-1:0] slot_pin;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [NUM_SLOTS-1:0][1:0]       slot_sense;
  logic [NUM_SLOTS-1:0]            hist_clr;
  logic [NUM_SLOTS-1:0]            stat_clr;
  logic [NUM_SLOTS-1:0]            slot_evt;
  logic [NUM_SLOTS-1:0]            status;

  gir_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gpio_in),
    .q   (gpio_s)
  );

  gir_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .status     (status),
    .slot_pin   (slot_pin),
    .slot_en    (slot_en),
    .slot_sense (slot_sense),
    .hist_clr   (hist_clr),
    .stat_clr   (stat_clr)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    gir_slot #(.NUM_PINS(NUM_PINS)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .gpio_s   (gpio_s),
      .pin      (slot_pin[s]),
      .en       (slot_en[s]),
      .sense    (slot_sense[s]),
      .hist_clr (hist_clr[s]),
      .clr      (stat_clr[s]),
      .evt      (slot_evt[s]),
      .status   (status[s])
    );
  end

  assign irq_out = status;
endmodule

// File: rtl/gir_checker.sv
module gir_checker #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [NUM_SLOTS-1:0] irq_out,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic [NUM_SLOTS-1:0] slot_evt,
  input logic [NUM_SLOTS-1:0] stat_clr
);
  localparam int SNS_WORDS = (NUM_SLOTS + 15) / 16;
  localparam int SEL_WORDS = (NUM_SLOTS + 3) / 4;

  logic mapped;
  always_comb begin
    mapped = (bus_addr == 8'h20) ||
             (int'(bus_addr) >= 'h24 && int'(bus_addr) < 'h24 + 4*SNS_WORDS && bus_addr[1:0] == 2'b00) ||
             (int'(bus_addr) >= 'h30 && int'(bus_addr) < 'h30 + 4*SEL_WORDS && bus_addr[1:0] == 2'b00);
  end

  // R1: lines are low on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0);

  // R8: no line rises unless its slot was enabled
  a_r8_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(irq_out) & ~$past(slot_en)) == '0);

  // R10: an event always leaves the line set on the next cycle
  a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(slot_evt) & ~irq_out) == '0);

  // R9: a line only drops after a clear aimed at it
  a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_out) & ~irq_out & ~$past(stat_clr)) == '0);

  // R12: unmapped offsets read as zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && !$past(mapped)) |-> bus_rdata == '0);
endmodule

bind gpio_irq_router gir_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .slot_en   (slot_en),
  .slot_evt  (slot_evt),
  .stat_clr  (stat_clr)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int NS = 32;
  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NS-1:0] irq_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_irq_router #(.NUM_SLOTS(NS), .NUM_PINS(NP)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .irq_out   (irq_out)
  );

  function automatic logic [7:0] sel_a(input int s);
    return 8'(8'h30 + 4 * (s / 4));
  endfunction

  function automatic logic [7:0] sns_a(input int s);
    return 8'(8'h24 + 4 * (s / 16));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] word;
    logic [31:0] bit_s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every mapped word and the lines
    chk("R1 irq after reset", 32'(irq_out), '0);
    rd(8'h20, rv); chk("R1 status", rv, '0);
    rd(8'h24, rv); chk("R1 sense lo", rv, '0);
    rd(8'h28, rv); chk("R1 sense hi", rv, '0);
    for (int w = 0; w < 8; w++) begin
      rd(8'(8'h30 + 4*w), rv); chk("R1 select", rv, '0);
    end

    // R3: sense field layout readback
    for (int w = 0; w < 2; w++) begin
      word = '0;
      for (int f = 0; f < 16; f++) word |= 32'((f + w) % 4) << (2*f);
      wr(8'(8'h24 + 4*w), word);
      rd(8'(8'h24 + 4*w), rv); chk("R3 sense readback", rv, word);
    end
    wr(8'h24, '0); wr(8'h28, '0);

    // R2: select byte layout readback (pins beyond range, gpio all low)
    for (int w = 0; w < 8; w++) begin
      word = '0;
      for (int l = 0; l < 4; l++)
        word |= 32'(((w*4 + l) % 2 ? 8'h80 : 8'h00) | 8'(7'd13 + 7'(w*4 + l)*7'd3)) << (8*l);
      wr(8'(8'h30 + 4*w), word);
      rd(8'(8'h30 + 4*w), rv); chk("R2 select readback", rv, word);
    end
    for (int w = 0; w < 8; w++) wr(8'(8'h30 + 4*w), '0);
    wr(8'h20, '0);
    settle();
    chk("R8 no status from rising sense on idle pins", 32'(irq_out), '0);

    // R4 R5 R6 R7 R10 R13: sweep every slot through every mode
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < 4; m++) begin
        int p;
        p = s % NP;
        bit_s = 32'(1) << s;
        gpio_in = '0;
        wr(sns_a(s), 32'(m) << (2*(s%16)));
        wr(sel_a(s), 32'(8'h80 | 8'(p)) << (8*(s%4)));
        settle();
        wr(8'h20, '0);
        chk($sformatf("R7 s%0d m%0d idle after clear", s, m), 32'(irq_out), (m == 3) ? bit_s : '0);
        gpio_in[p] = 1'b1;
        settle();
        chk($sformatf("R4 R5 R6 s%0d m%0d after rise", s, m), 32'(irq_out), (m == 1) ? '0 : bit_s);
        wr(8'h20, '0);
        chk($sformatf("R10 R6 s%0d m%0d clear while high", s, m), 32'(irq_out), (m == 2) ? bit_s : '0);
        gpio_in[p] = 1'b0;
        settle();
        chk($sformatf("R4 R5 R7 s%0d m%0d after fall", s, m), 32'(irq_out), (m == 0) ? '0 : bit_s);
        rd(8'h20, rv);
        chk($sformatf("R13 s%0d m%0d status matches lines", s, m), rv, 32'(irq_out));
        wr(sel_a(s), '0);
        wr(sns_a(s), '0);
        wr(8'h20, '0);
      end
    end
    chk("R6 lines clear after sweep", 32'(irq_out), '0);

    // R8: disabled slot with pin toggling
    wr(sel_a(5), 32'(8'h03) << 8);
    gpio_in[3] = 1'b1; settle();
    gpio_in[3] = 1'b0; settle();
    chk("R8 disabled slot stays low", 32'(irq_out), '0);
    wr(sel_a(5), '0);

    // R9: selective clear and write-one no-op
    wr(sel_a(2), 32'(8'h84) << 16);
    wr(sel_a(7), 32'(8'h86) << 24);
    settle();
    gpio_in[4] = 1'b1; gpio_in[6] = 1'b1; settle();
    gpio_in[4] = 1'b0; gpio_in[6] = 1'b0; settle();
    chk("R9 both set", 32'(irq_out), 32'h0000_0084);
    wr(8'h20, ~32'h4);
    rd(8'h20, rv); chk("R9 only bit 2 cleared", rv, 32'h0000_0080);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, rv); chk("R9 write ones no effect", rv, 32'h0000_0080);
    chk("R13 lines match status", 32'(irq_out), rv);
    wr(sel_a(2), '0); wr(sel_a(7), '0); wr(8'h20, '0);

    // R11: remap from low pin to high pin in rising mode
    gpio_in[1] = 1'b1;
    wr(sel_a(0), 32'h80);
    settle();
    chk("R11 baseline", 32'(irq_out), '0);
    wr(sel_a(0), 32'h81);
    settle();
    chk("R11 remap gives no false edge", 32'(irq_out), '0);
    gpio_in[1] = 1'b0; settle();
    gpio_in[1] = 1'b1; settle();
    chk("R11 real edge still seen", 32'(irq_out), 32'h1);
    wr(sel_a(0), '0); wr(8'h20, '0); gpio_in = '0;

    // R12: unmapped offsets and out-of-range pin index
    for (int k = 0; k < 5; k++) begin
      logic [7:0] ua;
      ua = (k == 0) ? 8'h00 : (k == 1) ? 8'h2C : (k == 2) ? 8'h50 : (k == 3) ? 8'h31 : 8'hFC;
      rd(ua, rv); chk($sformatf("R12 unmapped %h", ua), rv, '0);
    end
    gpio_in = '1;
    wr(sns_a(1), 32'(3) << 2);
    wr(sel_a(1), 32'(8'h80 | 8'd100) << 8);
    settle();
    chk("R12 out-of-range pin reads low", 32'(irq_out), 32'h2);
    wr(sns_a(1), 32'(2) << 2);
    wr(8'h20, '0);
    settle();
    chk("R12 out-of-range pin never high", 32'(irq_out), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule